// File: doc/BRIEF.md
# Three-Wire Synthesiser Control Word Loader

This block receives a serial control word over a three-line bus (data, shift clock and enable) and turns it into the static settings of a frequency synthesiser. Bits shift in only while enable is high. When enable goes low, the whole word moves into a holding register at once, so the fields that follow from it never show a half-loaded word.

The block decodes the held word into four groups of settings. These are a programmable divider ratio, a four-bit reference divider select and a two-bit charge-pump current code. The last group covers two open-drain port outputs and the charge-pump operating mode. A test bit changes the meaning of the two port bits. They then either force the charge pump to sink, to source or to switch off, or they route the comparison-frequency and halved-divider monitor signals out on the ports.

Each new word also raises a load strobe toward the divider. The strobe stays high until the divider acknowledges a cycle boundary, so the divider takes the new ratio without a glitch. The serial lines are asynchronous to the system clock and are oversampled through a synchroniser.

Top module: `tw_ctrl_loader`

## Requirements
- R1: A rising edge of the serial clock shifts a bit only while enable is high. Serial clock edges seen while enable is low leave the shift register unchanged. A load with no clocks therefore re-latches the previous word.
- R2: Bits enter MSB first. Whatever number of bits is clocked in, the held word is the last 26 bits shifted. With fewer than 26 bits, the older bits of the shift register fill the upper positions.
- R3: The held word updates only when enable falls, and the ratio output shows it. Word bit 25 is P1 and bit 24 is P0. Bit 23 is the test bit, bits 22:21 are C1:C0, bits 20:18 are R2:R0, bit 17 is RD and bits 16:0 are the ratio.
- R4: `ref_sel` equals {RD,R2,R1,R0} and `pump_cur` equals {C1,C0} of the held word.
- R5: `pump_mode` is encoded as 0 for normal, 1 for forced sink, 2 for forced source and 3 for off. With the test bit at 0 it is normal. With the test bit at 1, P1P0 of 00 gives sink, 01 gives source, 10 gives off and 11 gives normal.
- R6: With the test bit at 0, `port_sink[1]` equals P1 and `port_sink[0]` equals P0. A value of 1 means the open-drain output pulls low and 0 means it is released (high impedance).
- R7: With the test bit at 1 and P1P0 of 11, `port_sink[1]` repeats `fcomp_in` and `port_sink[0]` repeats `fpd_half_in`, each one clock later. With the test bit at 1 and any other P1P0 value, both ports are released.
- R8: `load_stb` rises in the clock that latches a new word and stays high until a cycle with `div_ack` high clears it. A latch in the same cycle as `div_ack` wins and leaves the strobe high.
- R9: While `rst` is high, every output is 0: the ports are released, the pump mode is normal and the strobe is low.
- R10: The held-word fields change three clocks after the enable pin is seen low. The pump mode and the ports change one clock after the held-word fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Serial enable; its falling edge latches the word |
| fcomp_in | input | 1 | Comparison-frequency monitor signal |
| fpd_half_in | input | 1 | Halved divider-output monitor signal |
| div_ack | input | 1 | Divider cycle-boundary acknowledge |
| ratio | output | 17 | Divider ratio from the held word |
| ref_sel | output | 4 | Reference divider select {RD,R2,R1,R0} |
| pump_cur | output | 2 | Charge-pump current code {C1,C0} |
| pump_mode | output | 2 | Charge-pump mode (normal, sink, source, off) |
| port_sink | output | 2 | Open-drain port pull-down enables, bit 1 for P1 |
| load_stb | output | 1 | New-word strobe toward the divider |

## Verification
The assertions assume slow serial lines. Each level of data, shift clock and enable is held for several system clocks, data is steady around the rising edge of the shift clock, and enable never falls while the shift clock is high. The monitor inputs and `div_ack` are taken to be synchronous to `clk`. The stimulus holds every serial phase for four clocks, changes data only while the shift clock is low, and drives all synchronous inputs on the falling edge of `clk`.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int RATIO_W = 17;
  localparam int CTRL_W  = 9;
  localparam int WORD_W  = RATIO_W + CTRL_W;

  typedef struct packed {
    logic               p1;
    logic               p0;
    logic               t0;
    logic               c1;
    logic               c0;
    logic               r2;
    logic               r1;
    logic               r0;
    logic               rd;
    logic [RATIO_W-1:0] ratio;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    PUMP_NORMAL = 2'd0,
    PUMP_SINK   = 2'd1,
    PUMP_SOURCE = 2'd2,
    PUMP_OFF    = 2'd3
  } pump_mode_e;
endpackage

// File: rtl/tw_frontend.sv
module tw_frontend #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_en,
  output logic shift_pulse,
  output logic shift_bit,
  output logic en_high,
  output logic en_fall
);
  localparam int LINES = 3;
  localparam int L_DAT = 0;
  localparam int L_CLK = 1;
  localparam int L_EN  = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now;
  logic             clk_last;
  logic             en_last;

  assign raw = {ser_en, ser_clk, ser_data};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign now[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_last <= 1'b0;
      en_last  <= 1'b0;
    end else begin
      clk_last <= now[L_CLK];
      en_last  <= now[L_EN];
    end
  end

  assign en_high     = now[L_EN];
  assign shift_bit   = now[L_DAT];
  assign shift_pulse = now[L_CLK] & ~clk_last & now[L_EN];
  assign en_fall     = en_last & ~now[L_EN];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_pulse,
  input  logic              shift_bit,
  input  logic              en_high,
  output logic [WORD_W-1:0] sreg
);
  always_ff @(posedge clk) begin
    if (rst)              sreg <= '0;
    else if (shift_pulse) sreg <= {sreg[WORD_W-2:0], shift_bit};
  end

  // R1: with enable low the register is frozen
  a_r1_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_high |=> $stable(sreg));

  // R2: each shift moves older bits toward the MSB
  a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> (sreg[WORD_W-1:1] == $past(sreg[WORD_W-2:0])));
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en_fall,
  input  logic [WORD_W-1:0]  sreg,
  input  logic               fcomp_in,
  input  logic               fpd_half_in,
  output logic [RATIO_W-1:0] ratio,
  output logic [3:0]         ref_sel,
  output logic [1:0]         pump_cur,
  output logic [1:0]         pump_mode,
  output logic [1:0]         port_sink
);
  ctrl_word_t word_q;
  pump_mode_e mode_d;
  pump_mode_e mode_q;
  logic [1:0] port_d;
  logic [1:0] sel_p;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (en_fall) word_q <= ctrl_word_t'(sreg);
  end

  assign sel_p = {word_q.p1, word_q.p0};

  always_comb begin
    mode_d = PUMP_NORMAL;
    port_d = sel_p;
    if (word_q.t0) begin
      port_d = 2'b00;
      unique case (sel_p)
        2'b00:   mode_d = PUMP_SINK;
        2'b01:   mode_d = PUMP_SOURCE;
        2'b10:   mode_d = PUMP_OFF;
        default: begin
          mode_d = PUMP_NORMAL;
          port_d = {fcomp_in, fpd_half_in};
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PUMP_NORMAL;
      port_sink <= 2'b00;
    end else begin
      mode_q    <= mode_d;
      port_sink <= port_d;
    end
  end

  assign ratio     = word_q.ratio;
  assign ref_sel   = {word_q.rd, word_q.r2, word_q.r1, word_q.r0};
  assign pump_cur  = {word_q.c1, word_q.c0};
  assign pump_mode = mode_q;

  // R3: the held word changes only on an enable fall
  a_r3_latch_on_fall: assert property (@(posedge clk) disable iff (rst)
    !en_fall |=> $stable(word_q));

  // R5: forced sink when test bit set with ports 00
  a_r5_forced_sink: assert property (@(posedge clk) disable iff (rst)
    (word_q.t0 && sel_p == 2'b00) |=> (pump_mode == PUMP_SINK));

  // R5: normal pump whenever the test bit is clear
  a_r5_normal_mode: assert property (@(posedge clk) disable iff (rst)
    !word_q.t0 |=> (pump_mode == PUMP_NORMAL));

  // R6: normal mode ports mirror the port bits
  a_r6_port_bits: assert property (@(posedge clk) disable iff (rst)
    !word_q.t0 |=> (port_sink == $past(sel_p)));

  // R7: monitor mode routes the two frequency signals
  a_r7_monitor: assert property (@(posedge clk) disable iff (rst)
    (word_q.t0 && sel_p == 2'b11) |=> (port_sink == $past({fcomp_in, fpd_half_in})));
endmodule

// File: rtl/tw_strobe.sv
module tw_strobe (
  input  logic clk,
  input  logic rst,
  input  logic en_fall,
  input  logic div_ack,
  output logic load_stb
);
  always_ff @(posedge clk) begin
    if (rst)          load_stb <= 1'b0;
    else if (en_fall) load_stb <= 1'b1;
    else if (div_ack) load_stb <= 1'b0;
  end

  // R8: a latch always raises the strobe
  a_r8_raise: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> load_stb);

  // R8: strobe held until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !div_ack) |=> load_stb);

  // R8: acknowledge without a new latch clears it
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (div_ack && !en_fall) |=> !load_stb);
endmodule

// File: rtl/tw_ctrl_loader.sv
module tw_ctrl_loader #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_en,
  input  logic                       fcomp_in,
  input  logic                       fpd_half_in,
  input  logic                       div_ack,
  output logic [tw_pkg::RATIO_W-1:0] ratio,
  output logic [3:0]                 ref_sel,
  output logic [1:0]                 pump_cur,
  output logic [1:0]                 pump_mode,
  output logic [1:0]                 port_sink,
  output logic                       load_stb
);
  import tw_pkg::*;

  logic              shift_pulse;
  logic              shift_bit;
  logic              en_high;
  logic              en_fall;
  logic [WORD_W-1:0] sreg;

  tw_frontend #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .shift_pulse(shift_pulse), .shift_bit(shift_bit),
    .en_high(en_high), .en_fall(en_fall)
  );

  tw_shift u_shift (
    .clk(clk), .rst(rst),
    .shift_pulse(shift_pulse), .shift_bit(shift_bit), .en_high(en_high),
    .sreg(sreg)
  );

  tw_decode u_decode (
    .clk(clk), .rst(rst), .en_fall(en_fall), .sreg(sreg),
    .fcomp_in(fcomp_in), .fpd_half_in(fpd_half_in),
    .ratio(ratio), .ref_sel(ref_sel), .pump_cur(pump_cur),
    .pump_mode(pump_mode), .port_sink(port_sink)
  );

  tw_strobe u_strobe (
    .clk(clk), .rst(rst), .en_fall(en_fall), .div_ack(div_ack),
    .load_stb(load_stb)
  );

  // R9: reset leaves ports released and strobe low
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (port_sink == 2'b00 && !load_stb && pump_mode == 2'd0));
endmodule

// File: tb/tb_tw_ctrl_loader.sv
module tb_tw_ctrl_loader;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PHASE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic fcomp_in = 1'b0, fpd_half_in = 1'b0, div_ack = 1'b0;
  logic [16:0] ratio;
  logic [3:0]  ref_sel;
  logic [1:0]  pump_cur, pump_mode, port_sink;
  logic        load_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_ctrl_loader dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .fcomp_in(fcomp_in), .fpd_half_in(fpd_half_in), .div_ack(div_ack),
    .ratio(ratio), .ref_sel(ref_sel), .pump_cur(pump_cur),
    .pump_mode(pump_mode), .port_sink(port_sink), .load_stb(load_stb)
  );

  // behavioural reference model, advanced on every rising edge
  logic [2:0]  h1 = '0, h2 = '0, h3 = '0;  // {en, clk, data} samples
  logic [25:0] m_sreg = '0, m_word = '0;
  logic [1:0]  m_pump = '0, m_port = '0;
  logic        m_stb = 1'b0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_sreg = '0; m_word = '0; m_pump = '0; m_port = '0; m_stb = 1'b0;
    end else begin
      if (!m_word[23]) begin
        m_pump = 2'd0; m_port = m_word[25:24];
      end else begin
        m_port = 2'b00;
        if (m_word[25:24] == 2'b00)      m_pump = 2'd1;
        else if (m_word[25:24] == 2'b01) m_pump = 2'd2;
        else if (m_word[25:24] == 2'b10) m_pump = 2'd3;
        else begin
          m_pump = 2'd0; m_port = {fcomp_in, fpd_half_in};
        end
      end
      if (h3[2] && !h2[2]) begin
        m_stb  = 1'b1;
        m_word = m_sreg;
      end else if (div_ack) m_stb = 1'b0;
      if (h2[1] && !h3[1] && h2[2]) m_sreg = {m_sreg[24:0], h2[0]};
      h3 = h2; h2 = h1; h1 = {ser_en, ser_clk, ser_data};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R3 ratio", 32'(ratio), 32'(m_word[16:0]));
      chk("R4 ref_sel", 32'(ref_sel), 32'({m_word[17], m_word[20:18]}));
      chk("R4 pump_cur", 32'(pump_cur), 32'(m_word[22:21]));
      chk("R5 pump_mode", 32'(pump_mode), 32'(m_pump));
      chk(m_word[23] ? "R7 port_sink" : "R6 port_sink", 32'(port_sink), 32'(m_port));
      chk("R8 load_stb", 32'(load_stb), 32'(m_stb));
    end
  end

  // free-running monitor patterns
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      fcomp_in    <= (k % 6) < 3;
      fpd_half_in <= (k % 10) < 5;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    @(negedge clk); ser_en = 1'b1; idle(PHASE);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i]; idle(PHASE);
      ser_clk = 1'b1;     idle(PHASE);
      ser_clk = 1'b0;
    end
    idle(PHASE);
    ser_en = 1'b0; idle(PHASE + 2);
  endtask

  function automatic logic [25:0] mk(input logic [1:0] p, input logic t0, input logic [1:0] c,
                                     input logic [2:0] r, input logic rd, input logic [16:0] rt);
    return {p, t0, c, r, rd, rt};
  endfunction

  task automatic ack_pulse();
    div_ack = 1'b1; idle(1); div_ack = 1'b0; idle(2);
  endtask

  initial begin
    logic [25:0] w;
    logic [25:0] old;
    logic [19:0] n20;
    idle(3);
    chk("R9 reset ports", 32'(port_sink), 32'd0);
    chk("R9 reset strobe", 32'(load_stb), 32'd0);
    chk("R9 reset ratio", 32'(ratio), 32'd0);
    rst = 1'b0; idle(3);

    // R3 R4 R6 R8: plain load
    w = mk(2'b01, 1'b0, 2'b10, 3'b101, 1'b1, 17'h1ABCD);
    send(64'(w), 26);
    chk("R3 loaded ratio", 32'(ratio), 32'h1ABCD);
    chk("R4 loaded ref_sel", 32'(ref_sel), 32'b1101);
    chk("R4 loaded pump_cur", 32'(pump_cur), 32'b10);
    chk("R6 port P0 on", 32'(port_sink), 32'b01);
    chk("R8 strobe set", 32'(load_stb), 32'd1);
    ack_pulse();
    chk("R8 strobe cleared", 32'(load_stb), 32'd0);

    // R1: clocks while enable low are ignored
    ser_data = 1'b1;
    for (int i = 0; i < 10; i++) begin
      ser_clk = 1'b1; idle(PHASE); ser_clk = 1'b0; idle(PHASE);
    end
    send(64'd0, 0);
    chk("R1 word unchanged", 32'(ratio), 32'h1ABCD);
    chk("R1 port unchanged", 32'(port_sink), 32'b01);
    ack_pulse();

    // R2: too many bits keep the last 26
    w = mk(2'b10, 1'b0, 2'b01, 3'b011, 1'b0, 17'h00F0F);
    send({34'h0, 4'hE, w}, 30);
    chk("R2 overlong ratio", 32'(ratio), 32'h00F0F);
    chk("R6 port P1 on", 32'(port_sink), 32'b10);
    // R2: too few bits leave older bits on top
    old = w; n20 = 20'hA5C3E;
    send(64'(n20), 20);
    w = {old[5:0], n20};
    chk("R2 short ratio", 32'(ratio), 32'(w[16:0]));
    chk("R2 short pump_cur", 32'(pump_cur), 32'(w[22:21]));

    // R5 R7: test modes
    send(64'(mk(2'b00, 1'b1, 2'b11, 3'b000, 1'b0, 17'h00100)), 26);
    chk("R5 forced sink", 32'(pump_mode), 32'd1);
    chk("R7 ports released", 32'(port_sink), 32'd0);
    send(64'(mk(2'b01, 1'b1, 2'b00, 3'b111, 1'b1, 17'h1FFFF)), 26);
    chk("R5 forced source", 32'(pump_mode), 32'd2);
    send(64'(mk(2'b10, 1'b1, 2'b01, 3'b010, 1'b0, 17'h00001)), 26);
    chk("R5 pump off", 32'(pump_mode), 32'd3);
    send(64'(mk(2'b11, 1'b1, 2'b10, 3'b100, 1'b1, 17'h12345)), 26);
    chk("R5 monitor pump normal", 32'(pump_mode), 32'd0);
    idle(30);  // R7: per-clock model follows the monitor signals

    // R8: latch while acknowledge held high; R10 timing via per-clock model
    div_ack = 1'b1;
    send(64'(mk(2'b11, 1'b0, 2'b00, 3'b001, 1'b0, 17'h0ACE1)), 26);
    div_ack = 1'b0;
    chk("R10 ratio after load", 32'(ratio), 32'h0ACE1);
    chk("R8 strobe cleared by held ack", 32'(load_stb), 32'd0);

    // R9: reset mid-run
    rst = 1'b1; idle(2);
    chk("R9 reset port", 32'(port_sink), 32'd0);
    chk("R9 reset ratio", 32'(ratio), 32'd0);
    rst = 1'b0; idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1..watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule